// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block derives the serial clock of an I2C master from the system clock. A programmable timer period sets the length of one timing unit: each unit is 2 × (1 + period) system clocks. Every SCL cycle is made of a low phase of six units followed by a high phase of four units. The duty cycle is therefore fixed at 60/40, and the register value sets the rate. Some example settings: a period of 2 at a 20 MHz clock gives about 333 kHz. A period of 9 at 20 MHz gives 100 kHz. A period of 4 at 40 MHz gives 400 kHz.

The protocol engine next to this block reads a level, `scl_low`, which tells it when to pull the bus clock low. It also gets two single-cycle strobes, one at the start of each phase, and uses them to place SDA changes. The engine wires the real SCL line back into `scl_in`. A slave that holds SCL low during the high phase freezes the unit counting, which supports clock stretching. A new period value is accepted only at the start of a low phase, so an SCL cycle that is already running is never distorted.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted, `scl_low`, `low_start` and `high_start` are all 0.
- R2: While `en` is 0, `scl_low` stays 0 (SCL released high) and neither strobe is produced.
- R3: In the first clock after `en` is seen at 1 from the idle state, `low_start` and `scl_low` are both 1.
- R4: With P the period value, the low phase keeps `scl_low` at 1 for exactly 12 × (P + 1) clocks.
- R5: The first clock with `scl_low` at 0 after a low phase carries `high_start` = 1. With `scl_in` held high, the high phase lasts 8 × (P + 1) clocks and ends in the clock that carries the next `low_start`.
- R6: A change of `period` during an SCL cycle does not affect that cycle. The new value applies from the next `low_start` onward.
- R7: During the high phase, every clock edge at which `scl_in` is sampled 0 freezes the unit count and lengthens the high phase by one clock. `scl_in` has no effect during the low phase.
- R8: Each strobe lasts exactly one clock, and the two strobes never occur together. `low_start` coincides with every rise of `scl_low`.
- R9: Dropping `en` in either phase gives `scl_low` = 0 and no strobes in the next clock. A later enable restarts with a full low phase.
- R10: The full SCL period is 20 × (P + 1) clocks. This holds at the extremes P = 0 (20 clocks) and P = 127 (2560 clocks), and at P = 9 (200 clocks, 100 kHz from 20 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Runs the SCL generator when 1 |
| period | input | 7 | Timer period P; one unit is 2 × (P + 1) clocks |
| scl_in | input | 1 | Sampled level of the SCL bus line (for stretching) |
| scl_low | output | 1 | 1 while SCL must be driven low |
| low_start | output | 1 | Single-cycle strobe at the first clock of a low phase |
| high_start | output | 1 | Single-cycle strobe at the first clock of a high phase |

## Verification
The hardest cases to reach from the ports are two: a stretched high phase whose freeze window crosses a unit boundary, and a period change that arrives in the middle of a running cycle. For stretching, the bench drives `scl_in` as a wired line. On a chosen clock inside the high phase it pulls the line low for a set number of clocks, and it checks that the high phase grows by exactly that count. In the same test it pulls the line low during a low phase and checks that the low length does not change. For the period change, the bench writes a new value a few clocks after `low_start`. It then measures the rest of that cycle against the old period and the following cycle against the new one.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/i2c_scl_line_sync.sv
module i2c_scl_line_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_hi
);

   generate
      if (STAGES == 0) begin : g_direct
         logic unused_sync_pins;
         assign unused_sync_pins = clk ^ rst_n;
         assign line_hi = line_in;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= line_in;
               for (int i = 1; i < STAGES; i++) begin
                  sr[i] <= sr[i-1];
               end
            end
         end
         assign line_hi = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_scl_prescaler.sv
module i2c_scl_prescaler #(
   parameter int PERIOD_W = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                advance,
   input  logic [PERIOD_W-1:0] period_q,
   output logic                unit_done
);

   localparam int CNT_W = PERIOD_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   // 2*(P+1)-1 = 2P+1
   assign limit     = {period_q, 1'b1};
   assign unit_done = advance && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || unit_done) begin
         cnt <= '0;
      end else if (advance) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_scl_phase_seq.sv
module i2c_scl_phase_seq
   import i2c_scl_pkg::*;
#(
   parameter int PERIOD_W   = 7,
   parameter int LOW_UNITS  = 6,
   parameter int HIGH_UNITS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                line_hi,
   input  logic                unit_done,
   input  logic [PERIOD_W-1:0] period_in,
   output logic [PERIOD_W-1:0] period_q,
   output logic                advance,
   output logic                clear,
   output scl_phase_e          phase,
   output logic                low_start,
   output logic                high_start
);

   localparam int UNIT_W = cnt_width(max_u(LOW_UNITS, HIGH_UNITS));
   localparam logic [UNIT_W-1:0] LOW_LAST  = UNIT_W'(LOW_UNITS - 1);
   localparam logic [UNIT_W-1:0] HIGH_LAST = UNIT_W'(HIGH_UNITS - 1);

   logic [UNIT_W-1:0] ucnt;
   logic              go_low;
   logic              go_high;
   logic              go_idle;

   always_comb begin
      go_low  = 1'b0;
      go_high = 1'b0;
      go_idle = 1'b0;
      if (!en) begin
         go_idle = (phase != PH_IDLE);
      end else begin
         unique case (phase)
            PH_IDLE: go_low  = 1'b1;
            PH_LOW:  go_high = unit_done && (ucnt == LOW_LAST);
            PH_HIGH: go_low  = unit_done && (ucnt == HIGH_LAST);
            default: go_idle = 1'b1;
         endcase
      end
   end

   assign advance = en && ((phase == PH_LOW) || ((phase == PH_HIGH) && line_hi));
   assign clear   = (phase == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         ucnt       <= '0;
         low_start  <= 1'b0;
         high_start <= 1'b0;
         period_q   <= '0;
      end else begin
         low_start  <= go_low;
         high_start <= go_high;
         if (go_idle) begin
            phase <= PH_IDLE;
         end else if (go_low) begin
            phase <= PH_LOW;
         end else if (go_high) begin
            phase <= PH_HIGH;
         end
         if (go_low || go_high || go_idle || (phase == PH_IDLE)) begin
            ucnt <= '0;
         end else if (unit_done) begin
            ucnt <= ucnt + 1'b1;
         end
         if (go_low) begin
            period_q <= period_in;
         end
      end
   end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
   import i2c_scl_pkg::*;
#(
   parameter int PERIOD_W    = 7,
   parameter int LOW_UNITS   = 6,
   parameter int HIGH_UNITS  = 4,
   parameter int SYNC_STAGES = 0,
   parameter bit STRETCH_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   input  logic                scl_in,
   output logic                scl_low,
   output logic                low_start,
   output logic                high_start
);

   if (PERIOD_W < 1 || PERIOD_W > 12) begin : g_bad_width
      $error("i2c_scl_timer: PERIOD_W out of range");
   end
   if (LOW_UNITS < 1 || HIGH_UNITS < 1) begin : g_bad_units
      $error("i2c_scl_timer: phase unit counts must be positive");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("i2c_scl_timer: SYNC_STAGES out of range");
   end

   logic                line_hi;
   logic                unit_done;
   logic                advance;
   logic                clear;
   logic [PERIOD_W-1:0] period_q;
   scl_phase_e          phase;

   generate
      if (STRETCH_EN) begin : g_stretch
         i2c_scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (scl_in),
            .line_hi (line_hi)
         );
      end else begin : g_no_stretch
         logic unused_scl_in;
         assign unused_scl_in = scl_in;
         assign line_hi = 1'b1;
      end
   endgenerate

   i2c_scl_prescaler #(.PERIOD_W(PERIOD_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .advance   (advance),
      .period_q  (period_q),
      .unit_done (unit_done)
   );

   i2c_scl_phase_seq #(
      .PERIOD_W   (PERIOD_W),
      .LOW_UNITS  (LOW_UNITS),
      .HIGH_UNITS (HIGH_UNITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .line_hi    (line_hi),
      .unit_done  (unit_done),
      .period_in  (period),
      .period_q   (period_q),
      .advance    (advance),
      .clear      (clear),
      .phase      (phase),
      .low_start  (low_start),
      .high_start (high_start)
   );

   assign scl_low = (phase == PH_LOW);

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
   parameter int PERIOD_W  = 7,
   parameter int LOW_UNITS = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                en,
   input logic                line_hi,
   input logic [PERIOD_W-1:0] period,
   input logic [PERIOD_W-1:0] period_q,
   input logic                scl_low,
   input logic                low_start,
   input logic                high_start
);

   logic [15:0] lowcnt_q;
   logic [15:0] low_limit;
   logic        hi_q;
   logic        hi_now;

   assign low_limit = 16'(LOW_UNITS) * (16'(period_q) + 16'd1) * 16'd2;
   assign hi_now    = high_start || hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowcnt_q <= '0;
         hi_q     <= 1'b0;
      end else begin
         lowcnt_q <= scl_low ? lowcnt_q + 16'd1 : 16'd0;
         hi_q     <= en && hi_now && !low_start;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!scl_low && !low_start && !high_start));

   assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_low && !low_start && !high_start));

   assert_low_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low |-> (lowcnt_q < low_limit));

   assert_high_follows_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_low) && en) |-> high_start);

   assert_period_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      low_start |-> (period_q == $past(period)));

   assert_period_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !low_start |-> $stable(period_q));

   assert_stretch_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hi_now && !line_hi) |=> !low_start);

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(low_start && high_start));

   assert_low_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      low_start |=> !low_start);

   assert_high_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      high_start |=> !high_start);

   assert_rise_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low) |-> low_start);

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(
   .PERIOD_W  (PERIOD_W),
   .LOW_UNITS (LOW_UNITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .line_hi    (line_hi),
   .period     (period),
   .period_q   (period_q),
   .scl_low    (scl_low),
   .low_start  (low_start),
   .high_start (high_start)
);

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [6:0] period = '0;
   logic       scl_in = 1'b1;
   logic       scl_low;
   logic       low_start;
   logic       high_start;

   int checks = 0;
   int errors = 0;
   int strobe_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2c_scl_timer i_i2c_scl_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .period     (period),
      .scl_in     (scl_in),
      .scl_low    (scl_low),
      .low_start  (low_start),
      .high_start (high_start)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at the negedge where low_start is seen; returns at the next one.
   task automatic measure(input int st_at, input int st_len, input bit pull_in_low,
                          output int lo, output int hi);
      int guard = 0;
      lo = 0;
      hi = 0;
      while (scl_low && guard < 6000) begin
         if (lo > 0 && low_start) strobe_bad++;
         if (high_start) strobe_bad++;
         if (pull_in_low) scl_in = (lo < 3 || lo >= 8);
         lo++;
         guard++;
         @(negedge clk);
      end
      scl_in = 1'b1;
      chk(high_start === 1'b1, "R5 high_start at first high clock", int'(high_start), 1);
      while (!low_start && guard < 12000) begin
         if (hi > 0 && high_start) strobe_bad++;
         if (scl_low) strobe_bad++;
         if (st_len > 0) scl_in = !(hi >= st_at && hi < st_at + st_len);
         hi++;
         guard++;
         @(negedge clk);
      end
      scl_in = 1'b1;
   endtask

   task automatic restart(input logic [6:0] p);
      @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      period = p;
      en = 1'b1;
      @(negedge clk);
      chk(low_start === 1'b1 && scl_low === 1'b1, "R3 start of low phase after enable",
          int'({low_start, scl_low}), 3);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(scl_low === 1'b0, "R1 scl_low in reset", int'(scl_low), 0);
      chk(low_start === 1'b0 && high_start === 1'b0, "R1 strobes in reset",
          int'({low_start, high_start}), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_idle();
      int act = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (scl_low || low_start || high_start) act++;
      end
      chk(act == 0, "R2 idle while disabled", act, 0);
   endtask

   task automatic t_basic(input logic [6:0] p, input int cycles);
      int lo, hi;
      restart(p);
      for (int c = 0; c < cycles; c++) begin
         measure(0, 0, 1'b0, lo, hi);
         chk(lo == 12 * (int'(p) + 1), "R4 low length", lo, 12 * (int'(p) + 1));
         chk(hi == 8 * (int'(p) + 1), "R5 high length", hi, 8 * (int'(p) + 1));
         chk(lo + hi == 20 * (int'(p) + 1), "R10 SCL period", lo + hi, 20 * (int'(p) + 1));
      end
   endtask

   task automatic t_period_change();
      int lo, hi;
      restart(7'd2);
      repeat (4) @(negedge clk);
      period = 7'd5;
      measure(0, 0, 1'b0, lo, hi);
      chk(lo == 36 - 4 && hi == 24, "R6 running cycle keeps old period", lo + hi, 56);
      measure(0, 0, 1'b0, lo, hi);
      chk(lo == 72 && hi == 48, "R6 next cycle uses new period", lo + hi, 120);
   endtask

   task automatic t_stretch();
      int lo, hi;
      restart(7'd1);
      measure(5, 7, 1'b1, lo, hi);
      chk(lo == 24, "R7 scl_in ignored in low phase", lo, 24);
      chk(hi == 16 + 7, "R7 high phase stretched", hi, 23);
      measure(0, 0, 1'b0, lo, hi);
      chk(hi == 16, "R7 unstretched high after release", hi, 16);
   endtask

   task automatic t_mid_disable();
      int lo, hi;
      restart(7'd3);
      repeat (5) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(!scl_low && !low_start && !high_start, "R9 disable in low phase",
          int'({scl_low, low_start, high_start}), 0);
      restart(7'd3);
      while (scl_low) @(negedge clk);
      repeat (3) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(!scl_low && !low_start && !high_start, "R9 disable in high phase",
          int'({scl_low, low_start, high_start}), 0);
      restart(7'd3);
      measure(0, 0, 1'b0, lo, hi);
      chk(lo == 48, "R9 full low after re-enable", lo, 48);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_basic(7'd2, 2);
      t_basic(7'd9, 1);
      t_basic(7'd0, 2);
      t_period_change();
      t_stretch();
      t_mid_disable();
      t_basic(7'd127, 1);
      chk(strobe_bad == 0, "R8 strobe width and exclusivity", strobe_bad, 0);
      en = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule